// File: doc/BRIEF.md
# Capture/Compare Channel with Preload

This block is one capture/compare channel of a general-purpose timer. It takes the value of a free-running counter, which is kept outside the block, and works in one of two modes. In output compare mode, software writes a compare value into a channel register. The block copies that value into an active compare register, which is matched against the counter. The match produces a one-clock compare pulse. In input capture mode, each capture pulse stores the counter value in the same channel register, and software reads it back from there.

In output compare mode the compare value is double-buffered. When the preload enable input is low, a write reaches the active compare register at the same clock edge that updates the channel register. When preload is enabled, the active register changes only on an update-event pulse. This lets software stage a new value at any time, and the switch-over happens at a period boundary. Register accesses use a simple write strobe and a read strobe. The read data is registered.

Top module: `ccp_channel`

## Requirements
- R1: Synchronous active-high reset clears the channel register, the active compare register, the compare output and the read data to zero. While reset is held, `cmp_o` and `rd_data_o` are 0. After reset is released, the active compare value is 0.
- R2: Mode select `mode_i` = 0 means output compare and 1 means input capture. In output compare mode with `pre_en_i` = 0, a write loads the channel register and the active compare register together at the same clock edge.
- R3: In output compare mode with `pre_en_i` = 1, a write changes only the channel register. The active register takes the channel register value at an `upd_i` pulse. If a write and `upd_i` occur in the same cycle, the active register takes the value held before that write.
- R4: In output compare mode, `cmp_o` is 1 in the cycle after a clock edge at which `cnt_i` equals the active compare value. Otherwise it is 0.
- R5: In input capture mode, a `cap_i` pulse stores `cnt_i` in the channel register. A later read returns that captured value.
- R6: In input capture mode, software writes do not change the channel register.
- R7: A read issued in the same cycle as a capture returns the channel value from before the capture. `rd_data_o` shows the read value one cycle after `rd_en_i` and holds it until the next read.
- R8: In output compare mode, a read returns the last written channel (preload) value, even before an update event has moved it into the active register.
- R9: In input capture mode, `cmp_o` stays 0. Update events leave the active compare register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | 16 | Free-running counter value |
| upd_i | input | 1 | Update-event pulse |
| cap_i | input | 1 | Capture-event pulse |
| pre_en_i | input | 1 | Preload enable for the compare value |
| mode_i | input | 1 | 0 = output compare, 1 = input capture |
| wr_en_i | input | 1 | Channel register write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Channel register read strobe |
| rd_data_o | output | 16 | Registered read data |
| cmp_o | output | 1 | Registered compare-match output |

## Verification
The active compare register cannot be read by software, so a wrong value in it shows up only on `cmp_o`. The pulse appears at the wrong counter value, one cycle after the counter passes that value. The bench therefore probes the active value by driving the counter to the expected value and to a neighbouring value. A wrong channel register value, caused by a missed capture, a write that was not ignored or a lost preload, appears on `rd_data_o` one cycle after the next read strobe. A read that races a capture shows the wrong value in that same cycle.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic {
    MODE_OC = 1'b0,
    MODE_IC = 1'b1
  } ccp_mode_e;
endpackage

// File: rtl/ccp_value_reg.sv
module ccp_value_reg
  import ccp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ccp_mode_e        mode,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             cap,
  input  logic [WIDTH-1:0] cnt,
  output logic [WIDTH-1:0] chan_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_q <= '0;
    end else if (mode == MODE_IC) begin
      if (cap) chan_q <= cnt;
    end else if (wr_en) begin
      chan_q <= wr_data;
    end
  end

  // R5: capture latches the counter
  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IC && cap) |=> (chan_q == $past(cnt)));
  // R6: writes ignored in input mode
  a_r6_wr_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IC && wr_en && !cap) |=> $stable(chan_q));
endmodule

// File: rtl/ccp_active_reg.sv
module ccp_active_reg
  import ccp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ccp_mode_e        mode,
  input  logic             pre_en,
  input  logic             upd,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] chan_q,
  output logic [WIDTH-1:0] active_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (mode == MODE_OC) begin
      if (!pre_en) begin
        if (wr_en) active_q <= wr_data;
      end else if (upd) begin
        active_q <= chan_q;
      end
    end
  end

  // R2: direct load without preload
  a_r2_direct: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OC && !pre_en && wr_en) |=> (active_q == $past(wr_data)));
  // R3: preload holds until update, then transfers old channel value
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OC && pre_en && !upd) |=> $stable(active_q));
  a_r3_transfer: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OC && pre_en && upd) |=> (active_q == $past(chan_q)));
  // R9: input mode never changes the active value
  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IC) |=> $stable(active_q));
endmodule

// File: rtl/ccp_match.sv
module ccp_match
  import ccp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  ccp_mode_e        mode,
  input  logic [WIDTH-1:0] cnt,
  input  logic [WIDTH-1:0] active_q,
  output logic             cmp_q
);
  logic hit;
  assign hit = (mode == MODE_OC) && (cnt == active_q);

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= 1'b0;
    else     cmp_q <= hit;
  end

  // R9: no compare output in input mode
  a_r9_no_cmp: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_IC) |=> !cmp_q);
  // R4: pulse only after a counter match
  a_r4_pulse: assert property (@(posedge clk) disable iff (rst)
    (cnt != active_q) |=> !cmp_q);
endmodule

// File: rtl/ccp_readback.sv
module ccp_readback #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [WIDTH-1:0] chan_q,
  output logic [WIDTH-1:0] rd_q
);
  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= chan_q;
  end

  // R7: read returns pre-edge channel value, then holds
  a_r7_read: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (rd_q == $past(chan_q)));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             upd_i,
  input  logic             cap_i,
  input  logic             pre_en_i,
  input  logic             mode_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             cmp_o
);
  ccp_mode_e        mode;
  logic [WIDTH-1:0] chan_q;
  logic [WIDTH-1:0] active_q;

  assign mode = ccp_mode_e'(mode_i);

  ccp_value_reg #(.WIDTH(WIDTH)) u_value (
    .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en_i), .wr_data(wr_data_i),
    .cap(cap_i), .cnt(cnt_i), .chan_q(chan_q)
  );

  ccp_active_reg #(.WIDTH(WIDTH)) u_active (
    .clk(clk), .rst(rst), .mode(mode), .pre_en(pre_en_i), .upd(upd_i),
    .wr_en(wr_en_i), .wr_data(wr_data_i), .chan_q(chan_q), .active_q(active_q)
  );

  ccp_match #(.WIDTH(WIDTH)) u_match (
    .clk(clk), .rst(rst), .mode(mode), .cnt(cnt_i), .active_q(active_q),
    .cmp_q(cmp_o)
  );

  ccp_readback #(.WIDTH(WIDTH)) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en_i), .chan_q(chan_q), .rd_q(rd_data_o)
  );

  // R1: outputs quiet one cycle into reset
  a_r1_reset: assert property (@(posedge clk)
    $past(rst) |-> (!cmp_o && rd_data_o == '0));
endmodule

// File: tb/ccp_channel_tb.sv
module ccp_channel_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] cnt_i = '0;
  logic         upd_i = 1'b0, cap_i = 1'b0, pre_en_i = 1'b0, mode_i = 1'b0;
  logic         wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic         cmp_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ccp_channel #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .cnt_i(cnt_i), .upd_i(upd_i), .cap_i(cap_i),
    .pre_en_i(pre_en_i), .mode_i(mode_i), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .cmp_o(cmp_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [W-1:0] v, logic with_upd);
    wr_en_i = 1'b1; wr_data_i = v; upd_i = with_upd;
    tick();
    wr_en_i = 1'b0; upd_i = 1'b0;
  endtask

  task automatic do_read(output logic [W-1:0] v);
    rd_en_i = 1'b1;
    tick();
    rd_en_i = 1'b0;
    v = rd_data_o;
  endtask

  task automatic pulse_upd();
    upd_i = 1'b1;
    tick();
    upd_i = 1'b0;
  endtask

  // active value seen through compare output
  task automatic probe_active(string req, logic [W-1:0] v);
    cnt_i = v;
    tick();
    check(req, {15'd0, cmp_o}, 16'd1);
    cnt_i = v + 16'd1;
    tick();
    check(req, {15'd0, cmp_o}, 16'd0);
  endtask

  task automatic t_reset();
    logic [W-1:0] r;
    rst = 1'b1;
    repeat (3) tick();
    check("R1 cmp in reset", {15'd0, cmp_o}, 16'd0);
    check("R1 rd in reset", rd_data_o, 16'd0);
    rst = 1'b0;
    mode_i = 1'b0;
    probe_active("R1 active zero", 16'h0000);
    do_read(r);
    check("R1 chan zero", r, 16'h0000);
  endtask

  task automatic t_direct();
    pre_en_i = 1'b0; mode_i = 1'b0;
    do_write(16'h1234, 1'b0);
    probe_active("R2 direct", 16'h1234);
    do_write(16'hFFFF, 1'b0);
    probe_active("R2 direct max", 16'hFFFF);
  endtask

  task automatic t_preload();
    logic [W-1:0] r;
    pre_en_i = 1'b1; mode_i = 1'b0;
    do_write(16'h00A5, 1'b0);
    probe_active("R3 held old", 16'hFFFF);
    do_read(r);
    check("R8 read preload", r, 16'h00A5);
    pulse_upd();
    probe_active("R3 after upd", 16'h00A5);
    do_write(16'h0777, 1'b1);
    probe_active("R3 same-cycle upd old", 16'h00A5);
    pulse_upd();
    probe_active("R3 second upd", 16'h0777);
  endtask

  task automatic t_compare();
    pre_en_i = 1'b0; mode_i = 1'b0;
    do_write(16'h0040, 1'b0);
    cnt_i = 16'h003F; tick();
    check("R4 below", {15'd0, cmp_o}, 16'd0);
    cnt_i = 16'h0040; tick();
    check("R4 match", {15'd0, cmp_o}, 16'd1);
    cnt_i = 16'h0041; tick();
    check("R4 one cycle", {15'd0, cmp_o}, 16'd0);
  endtask

  task automatic t_capture();
    logic [W-1:0] r;
    mode_i = 1'b1;
    cnt_i = 16'hBEEF; cap_i = 1'b1; tick(); cap_i = 1'b0;
    cnt_i = 16'h0001;
    do_read(r);
    check("R5 capture", r, 16'hBEEF);
    check("R9 cmp low", {15'd0, cmp_o}, 16'd0);
    do_write(16'h5555, 1'b0);
    do_read(r);
    check("R6 write ignored", r, 16'hBEEF);
    cnt_i = 16'hC0DE; cap_i = 1'b1; rd_en_i = 1'b1; tick();
    cap_i = 1'b0; rd_en_i = 1'b0;
    check("R7 race old", rd_data_o, 16'hBEEF);
    tick();
    check("R7 hold", rd_data_o, 16'hBEEF);
    do_read(r);
    check("R7 new after", r, 16'hC0DE);
    cnt_i = 16'h0040; tick();
    check("R9 no cmp at active", {15'd0, cmp_o}, 16'd0);
    pulse_upd();
    mode_i = 1'b0;
    probe_active("R9 active kept", 16'h0040);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_direct();
    t_preload();
    t_compare();
    t_capture();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule